// File: doc/BRIEF.md
# Age-Filtered Squash Redirect Unit

This unit sits at the retire end of an out-of-order pipeline and decides which back-end redirect requests reach the earlier stages. Each request lane carries a hardware-thread number, the instruction sequence number of the redirecting instruction, a redirect target PC and branch-misprediction details (a mispredict flag and a taken flag). For every thread the unit holds a watermark: the sequence number of the youngest instruction that the reorder buffer is still expected to hold.

A redirect is passed on only if it is older (numerically smaller) than its thread's watermark. Accepting it pulls the watermark back to the redirecting instruction's sequence number, so a later redirect from an instruction it has already squashed is dropped silently. Insertions into the reorder buffer move the watermark forward. Sequence numbers are unsigned and increase monotonically; wrap-around is not handled.

The broadcast to earlier stages is registered: a squash accepted in one cycle appears on the outputs in the next cycle as a one-cycle valid pulse carrying the squash-until sequence number, the target PC and the mispredict information.

Top module: `squash_redirect_unit`

## Requirements
- R1: A synchronous active-high reset sets every thread's watermark to 0 and clears every broadcast valid.
- R2: An insert on a thread, with no squash accepted on that thread in the same cycle, sets that thread's watermark to the inserted sequence number in the next cycle.
- R3: A request whose sequence number is smaller than its thread's current watermark produces, one cycle later, a one-cycle valid pulse on that thread's broadcast with the request's sequence number and target PC.
- R4: A request whose sequence number is equal to or larger than its thread's watermark is dropped: no valid pulse follows and the watermark is unchanged (unless an insert moves it).
- R5: When a squash is accepted, that thread's watermark becomes the squashing sequence number in the next cycle.
- R6: When several lanes address one thread in the same cycle, only the one with the smallest sequence number is considered; on equal sequence numbers the lowest-numbered lane wins.
- R7: When a squash is accepted on a thread in the same cycle as an insert on that thread, the squash wins and the insert is ignored.
- R8: Threads are independent: a lane's thread field (bits TID_W*i upward of the packed thread vector, value = thread index) routes it, and requests or inserts for one thread never change another thread's watermark or broadcast.
- R9: The broadcast mispredict flag copies the accepted request's flag; the broadcast taken flag is the request's taken flag when the mispredict flag is set and 0 otherwise.
- R10: The broadcast valid falls back to 0 in the cycle after a pulse unless a new squash was accepted in the meantime.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | NUM_LANES | Redirect request valid, one bit per lane |
| req_tid | input | NUM_LANES*TID_W | Thread number per lane, lane i at bits i*TID_W upward |
| req_seq | input | NUM_LANES*SEQ_W | Sequence number of the redirecting instruction per lane |
| req_pc | input | NUM_LANES*PC_W | Redirect target PC per lane |
| req_mispred | input | NUM_LANES | Redirect came from a mispredicted branch |
| req_taken | input | NUM_LANES | Branch resolved taken |
| ins_valid | input | NUM_THREADS | Reorder-buffer insert this cycle, per thread |
| ins_seq | input | NUM_THREADS*SEQ_W | Sequence number of the inserted instruction per thread |
| sq_valid | output | NUM_THREADS | One-cycle squash broadcast pulse per thread |
| sq_seq | output | NUM_THREADS*SEQ_W | Squash-until sequence number per thread |
| sq_pc | output | NUM_THREADS*PC_W | Redirect target PC per thread |
| sq_mispred | output | NUM_THREADS | Broadcast mispredict flag per thread |
| sq_taken | output | NUM_THREADS | Broadcast taken flag per thread (0 unless mispredict) |
| youngest_seq | output | NUM_THREADS*SEQ_W | Current watermark per thread |

## Verification
The bench sweeps every combination of watermark and two same-thread request sequence numbers on a four-bit configuration, so the strict "older than" boundary is hit at equality: a design comparing with less-or-equal would broadcast a redirect from the watermark instruction itself. Equal sequence numbers on both lanes expose a picker that favours the higher lane, and the mixed insert-plus-squash cycles catch a design that lets the insert overwrite the pulled-back watermark and thereby re-admits already squashed redirects. A pseudo-random phase with mixed thread fields catches cross-thread leakage and a taken flag that leaks through when no misprediction is signalled.

// File: rtl/sqr_pkg.sv
package sqr_pkg;
    // Source of the next watermark value for one thread.
    typedef enum logic [1:0] {
        WM_HOLD   = 2'd0,
        WM_INSERT = 2'd1,
        WM_SQUASH = 2'd2
    } wm_src_e;
endpackage

// File: rtl/sqr_oldest_pick.sv
module sqr_oldest_pick #(
    parameter int NUM_LANES = 2,
    parameter int TID_W     = 1,
    parameter int SEQ_W     = 16,
    parameter int PC_W      = 32,
    parameter int THREAD_ID = 0
) (
    input  logic [NUM_LANES-1:0]       req_valid,
    input  logic [NUM_LANES*TID_W-1:0] req_tid,
    input  logic [NUM_LANES*SEQ_W-1:0] req_seq,
    input  logic [NUM_LANES*PC_W-1:0]  req_pc,
    input  logic [NUM_LANES-1:0]       req_mispred,
    input  logic [NUM_LANES-1:0]       req_taken,
    output logic                       pick_hit,
    output logic [SEQ_W-1:0]           pick_seq,
    output logic [PC_W-1:0]            pick_pc,
    output logic                       pick_mispred,
    output logic                       pick_taken
);
    localparam logic [TID_W-1:0] MY_TID = TID_W'(THREAD_ID);

    // Lowest lane wins a tie: a later lane replaces only on strictly older.
    always_comb begin
        pick_hit     = 1'b0;
        pick_seq     = '0;
        pick_pc      = '0;
        pick_mispred = 1'b0;
        pick_taken   = 1'b0;
        for (int i = 0; i < NUM_LANES; i++) begin
            if (req_valid[i] && (req_tid[i*TID_W +: TID_W] == MY_TID)) begin
                if (!pick_hit || (req_seq[i*SEQ_W +: SEQ_W] < pick_seq)) begin
                    pick_hit     = 1'b1;
                    pick_seq     = req_seq[i*SEQ_W +: SEQ_W];
                    pick_pc      = req_pc[i*PC_W +: PC_W];
                    pick_mispred = req_mispred[i];
                    pick_taken   = req_taken[i];
                end
            end
        end
    end
endmodule

// File: rtl/sqr_thread_filter.sv
module sqr_thread_filter
    import sqr_pkg::*;
#(
    parameter int SEQ_W = 16,
    parameter int PC_W  = 32
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             pick_hit,
    input  logic [SEQ_W-1:0] pick_seq,
    input  logic [PC_W-1:0]  pick_pc,
    input  logic             pick_mispred,
    input  logic             pick_taken,
    input  logic             ins_valid,
    input  logic [SEQ_W-1:0] ins_seq,
    output logic             sq_valid,
    output logic [SEQ_W-1:0] sq_seq,
    output logic [PC_W-1:0]  sq_pc,
    output logic             sq_mispred,
    output logic             sq_taken,
    output logic [SEQ_W-1:0] youngest_seq
);
    typedef struct packed {
        logic [SEQ_W-1:0] wm;
        logic             valid;
        logic [SEQ_W-1:0] seq;
        logic [PC_W-1:0]  pc;
        logic             mispred;
        logic             taken;
    } filt_state_t;

    filt_state_t st_d, st_q;
    wm_src_e     src;

    always_comb begin
        st_d       = st_q;
        st_d.valid = 1'b0;
        if (pick_hit && (pick_seq < st_q.wm)) begin
            src = WM_SQUASH;
        end else if (ins_valid) begin
            src = WM_INSERT;
        end else begin
            src = WM_HOLD;
        end
        case (src)
            WM_SQUASH: begin
                st_d.wm      = pick_seq;
                st_d.valid   = 1'b1;
                st_d.seq     = pick_seq;
                st_d.pc      = pick_pc;
                st_d.mispred = pick_mispred;
                st_d.taken   = pick_mispred & pick_taken;
            end
            WM_INSERT: st_d.wm = ins_seq;
            default:   st_d.wm = st_q.wm;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign sq_valid     = st_q.valid;
    assign sq_seq       = st_q.seq;
    assign sq_pc        = st_q.pc;
    assign sq_mispred   = st_q.mispred;
    assign sq_taken     = st_q.taken;
    assign youngest_seq = st_q.wm;

    // R3
    bcast_older_chk: assert property (@(posedge clk) disable iff (rst)
        $rose(st_q.valid) |-> (st_q.seq < $past(st_q.wm)));

    // R5
    wm_pullback_chk: assert property (@(posedge clk) disable iff (rst)
        st_q.valid |-> (st_q.wm == st_q.seq));

    // R2
    wm_advance_chk: assert property (@(posedge clk) disable iff (rst)
        (st_q.wm > $past(st_q.wm)) |-> $past(ins_valid));

    // R9
    taken_gated_chk: assert property (@(posedge clk) disable iff (rst)
        st_q.taken |-> st_q.mispred);

    // R4
    drop_younger_chk: assert property (@(posedge clk) disable iff (rst)
        (pick_hit && (pick_seq >= st_q.wm)) |=> !st_q.valid);
endmodule

// File: rtl/squash_redirect_unit.sv
module squash_redirect_unit #(
    parameter int NUM_THREADS = 2,
    parameter int NUM_LANES   = 2,
    parameter int SEQ_W       = 16,
    parameter int PC_W        = 32,
    parameter int TID_W       = (NUM_THREADS > 1) ? $clog2(NUM_THREADS) : 1
) (
    input  logic                         clk,
    input  logic                         rst,
    input  logic [NUM_LANES-1:0]         req_valid,
    input  logic [NUM_LANES*TID_W-1:0]   req_tid,
    input  logic [NUM_LANES*SEQ_W-1:0]   req_seq,
    input  logic [NUM_LANES*PC_W-1:0]    req_pc,
    input  logic [NUM_LANES-1:0]         req_mispred,
    input  logic [NUM_LANES-1:0]         req_taken,
    input  logic [NUM_THREADS-1:0]       ins_valid,
    input  logic [NUM_THREADS*SEQ_W-1:0] ins_seq,
    output logic [NUM_THREADS-1:0]       sq_valid,
    output logic [NUM_THREADS*SEQ_W-1:0] sq_seq,
    output logic [NUM_THREADS*PC_W-1:0]  sq_pc,
    output logic [NUM_THREADS-1:0]       sq_mispred,
    output logic [NUM_THREADS-1:0]       sq_taken,
    output logic [NUM_THREADS*SEQ_W-1:0] youngest_seq
);
    for (genvar t = 0; t < NUM_THREADS; t++) begin : g_thr
        logic             hit;
        logic [SEQ_W-1:0] p_seq;
        logic [PC_W-1:0]  p_pc;
        logic             p_mis;
        logic             p_tk;

        sqr_oldest_pick #(
            .NUM_LANES (NUM_LANES),
            .TID_W     (TID_W),
            .SEQ_W     (SEQ_W),
            .PC_W      (PC_W),
            .THREAD_ID (t)
        ) u_pick (
            .req_valid    (req_valid),
            .req_tid      (req_tid),
            .req_seq      (req_seq),
            .req_pc       (req_pc),
            .req_mispred  (req_mispred),
            .req_taken    (req_taken),
            .pick_hit     (hit),
            .pick_seq     (p_seq),
            .pick_pc      (p_pc),
            .pick_mispred (p_mis),
            .pick_taken   (p_tk)
        );

        sqr_thread_filter #(
            .SEQ_W (SEQ_W),
            .PC_W  (PC_W)
        ) u_filt (
            .clk          (clk),
            .rst          (rst),
            .pick_hit     (hit),
            .pick_seq     (p_seq),
            .pick_pc      (p_pc),
            .pick_mispred (p_mis),
            .pick_taken   (p_tk),
            .ins_valid    (ins_valid[t]),
            .ins_seq      (ins_seq[t*SEQ_W +: SEQ_W]),
            .sq_valid     (sq_valid[t]),
            .sq_seq       (sq_seq[t*SEQ_W +: SEQ_W]),
            .sq_pc        (sq_pc[t*PC_W +: PC_W]),
            .sq_mispred   (sq_mispred[t]),
            .sq_taken     (sq_taken[t]),
            .youngest_seq (youngest_seq[t*SEQ_W +: SEQ_W])
        );
    end

    // R10
    pulse_once_chk: assert property (@(posedge clk) disable iff (rst)
        (sq_valid != '0) |=> ((sq_valid & $past(sq_valid)) == '0 ||
                              $past(req_valid) != '0));
endmodule

// File: tb/sim_squash_redirect_unit.sv
module sim_squash_redirect_unit;
    localparam int CLK_PERIOD = 10;
    localparam int NT    = 2;
    localparam int NL    = 2;
    localparam int SW    = 4;
    localparam int PW    = 8;
    localparam int TW    = 1;

    logic clk = 1'b0;
    logic rst = 1'b1;
    always #(CLK_PERIOD/2) clk = ~clk;

    logic [NL-1:0]    req_valid;
    logic [NL*TW-1:0] req_tid;
    logic [NL*SW-1:0] req_seq;
    logic [NL*PW-1:0] req_pc;
    logic [NL-1:0]    req_mispred;
    logic [NL-1:0]    req_taken;
    logic [NT-1:0]    ins_valid;
    logic [NT*SW-1:0] ins_seq;
    logic [NT-1:0]    sq_valid;
    logic [NT*SW-1:0] sq_seq;
    logic [NT*PW-1:0] sq_pc;
    logic [NT-1:0]    sq_mispred;
    logic [NT-1:0]    sq_taken;
    logic [NT*SW-1:0] youngest_seq;

    squash_redirect_unit #(
        .NUM_THREADS(NT), .NUM_LANES(NL), .SEQ_W(SW), .PC_W(PW), .TID_W(TW)
    ) u0 (
        .clk(clk), .rst(rst),
        .req_valid(req_valid), .req_tid(req_tid), .req_seq(req_seq),
        .req_pc(req_pc), .req_mispred(req_mispred), .req_taken(req_taken),
        .ins_valid(ins_valid), .ins_seq(ins_seq),
        .sq_valid(sq_valid), .sq_seq(sq_seq), .sq_pc(sq_pc),
        .sq_mispred(sq_mispred), .sq_taken(sq_taken),
        .youngest_seq(youngest_seq)
    );

    // Bench-side stimulus arrays
    logic          b_rv  [NL];
    int            b_tid [NL];
    int            b_seq [NL];
    int            b_pc  [NL];
    logic          b_mis [NL];
    logic          b_tk  [NL];
    logic          b_iv  [NT];
    int            b_is  [NT];

    always_comb begin
        for (int i = 0; i < NL; i++) begin
            req_valid[i]            = b_rv[i];
            req_tid[i*TW +: TW]     = TW'(b_tid[i]);
            req_seq[i*SW +: SW]     = SW'(b_seq[i]);
            req_pc[i*PW +: PW]      = PW'(b_pc[i]);
            req_mispred[i]          = b_mis[i];
            req_taken[i]            = b_tk[i];
        end
        for (int t = 0; t < NT; t++) begin
            ins_valid[t]            = b_iv[t];
            ins_seq[t*SW +: SW]     = SW'(b_is[t]);
        end
    end

    // Model state and expectations
    int   m_wm  [NT];
    logic e_v   [NT];
    int   e_seq [NT];
    int   e_pc  [NT];
    logic e_mis [NT];
    logic e_tk  [NT];
    logic e_ins [NT];
    logic e_req [NT];
    int   e_nreq[NT];

    int n_checks = 0;
    int n_fail   = 0;
    int cyc      = 0;

    task automatic chk(input string tag, input int t, input int act, input int exp);
        n_checks++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s thread %0d cycle %0d: actual %0d expected %0d",
                     tag, t, cyc, act, exp);
        end
    endtask

    task automatic clear_inputs();
        for (int i = 0; i < NL; i++) begin
            b_rv[i] = 1'b0; b_tid[i] = 0; b_seq[i] = 0;
            b_pc[i] = 0; b_mis[i] = 1'b0; b_tk[i] = 1'b0;
        end
        for (int t = 0; t < NT; t++) begin
            b_iv[t] = 1'b0; b_is[t] = 0;
        end
    endtask

    // Compute expectations from the requirements, advance one clock, compare.
    task automatic step();
        for (int t = 0; t < NT; t++) begin
            int  best;
            int  bl;
            bit  found;
            found = 0; best = 0; bl = 0; e_nreq[t] = 0;
            for (int i = 0; i < NL; i++) begin
                if (b_rv[i] && b_tid[i] == t) begin
                    e_nreq[t]++;
                    if (!found || b_seq[i] < best) begin   // R6
                        found = 1; best = b_seq[i]; bl = i;
                    end
                end
            end
            e_req[t] = found;
            e_ins[t] = b_iv[t];
            if (found && best < m_wm[t]) begin
                e_v[t]   = 1'b1;
                e_seq[t] = best;
                e_pc[t]  = b_pc[bl];
                e_mis[t] = b_mis[bl];
                e_tk[t]  = b_mis[bl] & b_tk[bl];
                m_wm[t]  = best;
            end else begin
                e_v[t] = 1'b0;
                if (b_iv[t]) m_wm[t] = b_is[t];
            end
        end
        @(negedge clk);
        cyc++;
        for (int t = 0; t < NT; t++) begin
            string vtag;
            string wtag;
            vtag = e_v[t] ? "R3" : (e_req[t] ? "R4" : "R10");
            wtag = e_v[t] ? (e_ins[t] ? "R7" : "R5") : (e_ins[t] ? "R2" : "R8");
            chk(vtag, t, int'(sq_valid[t]), int'(e_v[t]));
            chk(wtag, t, int'(youngest_seq[t*SW +: SW]), m_wm[t]);
            if (e_v[t]) begin
                chk(e_nreq[t] > 1 ? "R6" : "R3", t, int'(sq_seq[t*SW +: SW]), e_seq[t]);
                chk(e_nreq[t] > 1 ? "R6" : "R3", t, int'(sq_pc[t*PW +: PW]), e_pc[t]);
                chk("R9", t, int'(sq_mispred[t]), int'(e_mis[t]));
                chk("R9", t, int'(sq_taken[t]), int'(e_tk[t]));
            end
        end
    endtask

    initial begin : watchdog
        repeat (100000) @(posedge clk);
        n_checks++;
        n_fail++;
        $display("FAIL watchdog expired: actual hung expected finished");
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
        $finish;
    end

    initial begin : main
        logic [15:0] lfsr;
        clear_inputs();
        for (int t = 0; t < NT; t++) m_wm[t] = 0;
        repeat (3) @(negedge clk);
        // R1: reset state
        for (int t = 0; t < NT; t++) begin
            chk("R1", t, int'(sq_valid[t]), 0);
            chk("R1", t, int'(youngest_seq[t*SW +: SW]), 0);
        end
        rst = 1'b0;

        // Exhaustive sweep: watermark x lane0 seq x lane1 seq, both threads
        for (int t = 0; t < NT; t++) begin
            for (int w = 0; w < 16; w++) begin
                for (int s0 = 0; s0 < 16; s0++) begin
                    for (int s1 = 0; s1 < 16; s1++) begin
                        clear_inputs();
                        b_iv[t] = 1'b1; b_is[t] = w;
                        b_iv[1-t] = 1'b1; b_is[1-t] = w ^ 5;
                        step();
                        clear_inputs();
                        b_rv[0] = 1'b1; b_tid[0] = t; b_seq[0] = s0;
                        b_pc[0] = s0 * 4 + t; b_mis[0] = s0[0]; b_tk[0] = s1[0];
                        b_rv[1] = 1'b1; b_tid[1] = t; b_seq[1] = s1;
                        b_pc[1] = 128 + s1 * 4 + t; b_mis[1] = s1[1]; b_tk[1] = s0[1];
                        b_iv[t] = s1[2]; b_is[t] = 15 - s0;
                        step();
                        clear_inputs();
                        step();
                    end
                end
            end
        end

        // Pseudo-random mixed-thread phase (R8)
        lfsr = 16'hACE1;
        for (int k = 0; k < 3000; k++) begin
            clear_inputs();
            for (int i = 0; i < NL; i++) begin
                lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
                b_rv[i]  = lfsr[0];
                b_tid[i] = int'(lfsr[1]);
                b_seq[i] = int'(lfsr[5:2]);
                b_pc[i]  = int'(lfsr[13:6]);
                b_mis[i] = lfsr[14];
                b_tk[i]  = lfsr[15];
            end
            for (int t = 0; t < NT; t++) begin
                lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
                b_iv[t] = lfsr[0] & lfsr[1];
                b_is[t] = int'(lfsr[7:4]);
            end
            step();
        end

        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
        $finish;
    end
endmodule